// File: doc/BRIEF.md
# Receive Lock Decision Controller

This block chooses what the receive clock recovery loop follows: the incoming serial data, or the local reference clock. It runs in the recovered word clock domain and takes one recovered parallel word per cycle. It also takes a per-cycle count of the reference clock edges seen since the previous word clock. From these inputs it makes two independent judgements.

The first judgement is a frequency-offset measurement. A window closes once a fixed number of reference edges has been counted. The number of recovered words in that window is then compared with the window length. The size of the difference is classified against ppm bounds, and the bounds depend on whether the loop is currently in frequency lock. The second judgement is a whole-word run-length detector, which raises loss of signal after a long stretch of identical bits.

The data-tracking select rises only when three things hold for the closing window: frequency lock, no loss of signal, and no force-to-reference request. The select is re-evaluated only when a window closes.

Top module: `rx_lock_ctrl`

## Requirements
- R1: When not in frequency lock, a closed window whose offset magnitude is below the acquire bound sets frequency lock. The acquire bound is round(2^WIN_LOG2 * 244 / 10^6) words.
- R2: When in frequency lock, a closed window whose offset magnitude is above the drop bound clears frequency lock. The drop bound is round(2^WIN_LOG2 * 732 / 10^6) words.
- R3: An offset in the undetermined band leaves the frequency lock state unchanged. For the locked state the band runs from round(2^WIN_LOG2 * 488 / 10^6) to the drop bound, inclusive. For the unlocked state it runs from the acquire bound to round(2^WIN_LOG2 * 366 / 10^6), inclusive. An unlocked state with any offset at or above the acquire bound stays unlocked.
- R4: A window closes on the cycle in which the accumulated ref_inc_i values (0 to 3 edges per cycle) reach 2^WIN_LOG2. Any excess carries into the next window. The offset is the absolute difference between 2^WIN_LOG2 and the number of cycles in the window, counting the closing cycle.
- R5: If 2 * 2^WIN_LOG2 cycles pass without the window closing, the window closes anyway with an offset of 2^WIN_LOG2, which clears frequency lock.
- R6: los_o goes high in the cycle after the 12th consecutive word that is entirely ones, or entirely zeros, with the same polarity throughout. A run of 119 identical bits never raises it. A run of 129 identical bits always raises it.
- R7: A word that mixes ones and zeros clears los_o at the next edge. A uniform word of the opposite polarity restarts the count at one.
- R8: At a window close, lock_data_o is set to 1 only if the new frequency lock state is locked and los_o was low on every cycle of the window.
- R9: If force_ref_ni is low on any cycle of a window, lock_data_o is 0 after that window closes.
- R10: lock_data_o and freq_lock_o change only at the edge on which a window closes.
- R11: While rst_ni is low, lock_data_o, los_o and freq_lock_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | WORD_W | Recovered parallel word; bit 0 is the first bit received |
| ref_inc_i | input | 2 | Reference clock edges seen since the previous word clock |
| force_ref_ni | input | 1 | Active low: force the loop onto the reference |
| lock_data_o | output | 1 | 1 = track the data, 0 = track the reference |
| los_o | output | 1 | Loss of signal from the run-length detector |
| freq_lock_o | output | 1 | Current frequency lock state |

## Verification
Several rules are checked on every cycle:
- the select and the lock state move only at a window close;
- every lock entry or exit respects its bound on the measured offset;
- a rising select never follows a cycle with force asserted or loss of signal present;
- loss of signal rises only after a uniform word and drops after a mixed word.

Other behaviour can only be shown by the bench's scenarios:
- that a given offset actually produces the expected lock transition, including both edges of each undetermined band and negative offsets;
- the stalled-reference timeout;
- the exact 119-bit and 129-bit run cases;
- that force or loss of signal anywhere inside a window blocks the select.

// File: rtl/rx_lock_pkg.sv
package rx_lock_pkg;

  typedef enum logic {
    LS_UNLOCKED = 1'b0,
    LS_LOCKED   = 1'b1
  } lock_state_e;

  typedef enum logic [1:0] {
    FV_LOCK   = 2'd0,
    FV_UNDET  = 2'd1,
    FV_UNLOCK = 2'd2
  } freq_verdict_e;

  // rounded count of words that a ppm offset represents over a window
  function automatic int unsigned ppm_to_count(input int unsigned win, input int unsigned ppm);
    longint unsigned prod;
    prod = longint'(win) * longint'(ppm) + 64'd500000;
    return int'(prod / 64'd1000000);
  endfunction

endpackage

// File: rtl/rx_freq_meter.sv
module rx_freq_meter #(
  parameter int unsigned WIN_LOG2 = 15,
  parameter int unsigned INC_W    = 2,
  localparam int unsigned MAG_W   = WIN_LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] ref_inc_i,
  output logic             win_end_o,
  output logic [MAG_W-1:0] off_mag_o
);

  localparam int unsigned WIN   = 1 << WIN_LOG2;
  localparam int unsigned CNT_W = WIN_LOG2 + 2;
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] TMO_C = CNT_W'(2 * WIN - 1);

  logic [CNT_W-1:0] ref_acc_q, rec_cnt_q;
  logic [CNT_W-1:0] ref_sum, meas, diff;
  logic             full, tmo;

  always_comb begin
    ref_sum   = ref_acc_q + CNT_W'(ref_inc_i);
    full      = ref_sum >= WIN_C;
    tmo       = rec_cnt_q == TMO_C;
    meas      = rec_cnt_q + CNT_W'(1);
    diff      = (meas >= WIN_C) ? (meas - WIN_C) : (WIN_C - meas);
    win_end_o = full | tmo;
    off_mag_o = diff[MAG_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_acc_q <= '0;
      rec_cnt_q <= '0;
    end else if (win_end_o) begin
      rec_cnt_q <= '0;
      ref_acc_q <= full ? (ref_sum - WIN_C) : '0;
    end else begin
      rec_cnt_q <= meas;
      ref_acc_q <= ref_sum;
    end
  end

endmodule

// File: rtl/rx_run_detect.sv
module rx_run_detect #(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned RUN_WORDS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              los_o
);

  localparam int unsigned RC_W = $clog2(RUN_WORDS + 1);
  localparam logic [RC_W-1:0] RC_MAX = RC_W'(RUN_WORDS);

  logic [RC_W-1:0] run_cnt_q;
  logic            pol_q;
  logic            all_one, all_zero;

  assign all_one  = &word_i;
  assign all_zero = ~|word_i;
  assign los_o    = run_cnt_q == RC_MAX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt_q <= '0;
      pol_q     <= 1'b0;
    end else if (all_one || all_zero) begin
      pol_q <= all_one;
      if (run_cnt_q != '0 && pol_q == all_one)
        run_cnt_q <= (run_cnt_q == RC_MAX) ? run_cnt_q : run_cnt_q + RC_W'(1);
      else
        run_cnt_q <= RC_W'(1);
    end else begin
      run_cnt_q <= '0;
    end
  end

endmodule

// File: rtl/rx_lock_fsm.sv
module rx_lock_fsm
  import rx_lock_pkg::*;
#(
  parameter int unsigned MAG_W  = 16,
  parameter int unsigned HOLD_T = 16,
  parameter int unsigned DROP_T = 24,
  parameter int unsigned ACQ_T  = 8,
  parameter int unsigned REJ_T  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_end_i,
  input  logic [MAG_W-1:0] off_mag_i,
  input  logic             force_ref_ni,
  input  logic             los_i,
  output logic             freq_lock_o,
  output logic             lock_data_o
);

  lock_state_e   state_q, state_d;
  freq_verdict_e verdict;
  logic          frc_seen_q, los_seen_q, blocked;
  logic          sel_q;

  always_comb begin
    if (state_q == LS_LOCKED) begin
      if (off_mag_i < MAG_W'(HOLD_T))      verdict = FV_LOCK;
      else if (off_mag_i > MAG_W'(DROP_T)) verdict = FV_UNLOCK;
      else                                 verdict = FV_UNDET;
    end else begin
      if (off_mag_i < MAG_W'(ACQ_T))       verdict = FV_LOCK;
      else if (off_mag_i > MAG_W'(REJ_T))  verdict = FV_UNLOCK;
      else                                 verdict = FV_UNDET;
    end
    case (verdict)
      FV_LOCK:   state_d = LS_LOCKED;
      FV_UNLOCK: state_d = LS_UNLOCKED;
      default:   state_d = state_q;
    endcase
    blocked = frc_seen_q | ~force_ref_ni | los_seen_q | los_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= LS_UNLOCKED;
      sel_q      <= 1'b0;
      frc_seen_q <= 1'b0;
      los_seen_q <= 1'b0;
    end else if (win_end_i) begin
      state_q    <= state_d;
      sel_q      <= (state_d == LS_LOCKED) && !blocked;
      frc_seen_q <= 1'b0;
      los_seen_q <= 1'b0;
    end else begin
      frc_seen_q <= frc_seen_q | ~force_ref_ni;
      los_seen_q <= los_seen_q | los_i;
    end
  end

  assign freq_lock_o = state_q == LS_LOCKED;
  assign lock_data_o = sel_q;

endmodule

// File: rtl/rx_lock_ctrl.sv
module rx_lock_ctrl
  import rx_lock_pkg::*;
#(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned WIN_LOG2  = 15,
  parameter int unsigned RUN_WORDS = 12,
  parameter int unsigned HOLD_PPM  = 488,
  parameter int unsigned DROP_PPM  = 732,
  parameter int unsigned ACQ_PPM   = 244,
  parameter int unsigned REJ_PPM   = 366
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        ref_inc_i,
  input  logic              force_ref_ni,
  output logic              lock_data_o,
  output logic              los_o,
  output logic              freq_lock_o
);

  localparam int unsigned WIN    = 1 << WIN_LOG2;
  localparam int unsigned MAG_W  = WIN_LOG2 + 1;
  localparam int unsigned HOLD_T = ppm_to_count(WIN, HOLD_PPM);
  localparam int unsigned DROP_T = ppm_to_count(WIN, DROP_PPM);
  localparam int unsigned ACQ_T  = ppm_to_count(WIN, ACQ_PPM);
  localparam int unsigned REJ_T  = ppm_to_count(WIN, REJ_PPM);

  logic             win_end;
  logic [MAG_W-1:0] off_mag;

  rx_freq_meter #(
    .WIN_LOG2(WIN_LOG2),
    .INC_W   (2)
  ) meter_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_inc_i(ref_inc_i),
    .win_end_o(win_end),
    .off_mag_o(off_mag)
  );

  rx_run_detect #(
    .WORD_W   (WORD_W),
    .RUN_WORDS(RUN_WORDS)
  ) run_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .word_i(word_i),
    .los_o (los_o)
  );

  rx_lock_fsm #(
    .MAG_W (MAG_W),
    .HOLD_T(HOLD_T),
    .DROP_T(DROP_T),
    .ACQ_T (ACQ_T),
    .REJ_T (REJ_T)
  ) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_end_i   (win_end),
    .off_mag_i   (off_mag),
    .force_ref_ni(force_ref_ni),
    .los_i       (los_o),
    .freq_lock_o (freq_lock_o),
    .lock_data_o (lock_data_o)
  );

endmodule

// File: rtl/rx_lock_ctrl_chk.sv
module rx_lock_ctrl_chk #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned MAG_W  = 16,
  parameter int unsigned ACQ_T  = 8,
  parameter int unsigned DROP_T = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_i,
  input logic              force_ref_ni,
  input logic              lock_data_o,
  input logic              los_o,
  input logic              freq_lock_o,
  input logic              win_end_i,
  input logic [MAG_W-1:0]  off_mag_i
);

  always @(negedge clk_i)
    if (!rst_ni)
      assert_reset_R11: assert (!lock_data_o && !los_o && !freq_lock_o);

  assert_sel_at_close_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_data_o) |-> $past(win_end_i));

  assert_state_at_close_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(freq_lock_o) |-> $past(win_end_i));

  assert_acquire_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(freq_lock_o) |-> ($past(off_mag_i) < MAG_W'(ACQ_T)));

  assert_drop_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(freq_lock_o) |-> ($past(off_mag_i) > MAG_W'(DROP_T)));

  assert_sel_needs_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_data_o |-> freq_lock_o);

  assert_sel_no_los_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_data_o) |-> !$past(los_o));

  assert_sel_force_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_data_o) |-> $past(force_ref_ni));

  assert_los_uniform_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |-> ($past(&word_i) || $past(~|word_i)));

  assert_los_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|word_i) && !(&word_i)) |=> !los_o);

endmodule

bind rx_lock_ctrl rx_lock_ctrl_chk #(
  .WORD_W(WORD_W),
  .MAG_W (MAG_W),
  .ACQ_T (ACQ_T),
  .DROP_T(DROP_T)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_i      (word_i),
  .force_ref_ni(force_ref_ni),
  .lock_data_o (lock_data_o),
  .los_o       (los_o),
  .freq_lock_o (freq_lock_o),
  .win_end_i   (win_end),
  .off_mag_i   (off_mag)
);

// File: tb/rx_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module rx_lock_ctrl_tb_top;

  localparam int WORD_W   = 10;
  localparam int WIN_LOG2 = 13;
  localparam int WIN      = 1 << WIN_LOG2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic [WORD_W-1:0] word = '0;
  logic [1:0]        ref_inc = 2'd0;
  logic              force_n = 1'b1;
  logic              lock_data, los, freq_lock;

  int    n_chk = 0, n_fail = 0;
  bit    exp_locked = 1'b0, exp_sel = 1'b0;
  string prev_tag = "R11";

  logic [WORD_W-1:0] sp_w[$];
  bit                sp_l[$];
  string             sp_t[$];

  always #2.5 clk = ~clk;

  rx_lock_ctrl #(.WORD_W(WORD_W), .WIN_LOG2(WIN_LOG2)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .word_i      (word),
    .ref_inc_i   (ref_inc),
    .force_ref_ni(force_n),
    .lock_data_o (lock_data),
    .los_o       (los),
    .freq_lock_o (freq_lock)
  );

  function automatic int bound(input int ppm);
    return (WIN * ppm + 500000) / 1000000;
  endfunction

  function automatic bit next_lock(input bit cur, input int mag);
    if (cur) return mag <= bound(732);
    return mag < bound(244);
  endfunction

  function automatic logic [WORD_W-1:0] rnd_word();
    logic [WORD_W-1:0] w;
    w = WORD_W'($urandom);
    if (&w || ~|w) w = 10'h155;
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic [1:0] inc, input logic [WORD_W-1:0] w);
    ref_inc = inc;
    word    = w;
    @(negedge clk);
  endtask

  task automatic push(input logic [WORD_W-1:0] w, input bit l, input string t);
    sp_w.push_back(w);
    sp_l.push_back(l);
    sp_t.push_back(t);
  endtask

  task automatic run_window(input int delta, input bit frc_n, input string tag);
    int  n;
    bit  los_hit;
    n       = WIN + delta;
    los_hit = 1'b0;
    force_n = frc_n;
    for (int i = 0; i < n; i++) begin
      logic [1:0]        inc;
      logic [WORD_W-1:0] w;
      bit                is_sp, el;
      string             et;
      inc   = (delta > 0 && i < delta) ? 2'd0 : (delta < 0 && i < -delta) ? 2'd2 : 2'd1;
      is_sp = (i >= 100) && (sp_w.size() > 0);
      el    = 1'b0;
      et    = "";
      if (is_sp) begin
        w  = sp_w.pop_front();
        el = sp_l.pop_front();
        et = sp_t.pop_front();
      end else begin
        w = rnd_word();
      end
      tick(inc, w);
      if (is_sp) begin
        chk(et, "los_o", los, el);
        if (el) los_hit = 1'b1;
      end
      if (i == 10) begin
        chk(prev_tag, "freq_lock_o", freq_lock, exp_locked);
        chk(prev_tag, "lock_data_o", lock_data, exp_sel);
      end
      if (i == n - 2) begin
        chk("R10", "lock_data_o held", lock_data, exp_sel);
        chk("R10", "freq_lock_o held", freq_lock, exp_locked);
      end
    end
    exp_locked = next_lock(exp_locked, (delta < 0) ? -delta : delta);
    exp_sel    = frc_n && exp_locked && !los_hit;
    prev_tag   = tag;
  endtask

  task automatic run_timeout();
    force_n = 1'b1;
    for (int i = 0; i < 2 * WIN; i++) tick(2'd0, rnd_word());
    exp_locked = 1'b0;
    exp_sel    = 1'b0;
    prev_tag   = "R5";
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "lock_data_o", lock_data, 1'b0);
    chk("R11", "los_o", los, 1'b0);
    chk("R11", "freq_lock_o", freq_lock, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    run_window(0, 1'b1, "R1");
    run_window(5, 1'b1, "R3");
    run_window(6, 1'b1, "R3");
    run_window(-7, 1'b1, "R2");
    run_window(3, 1'b1, "R3");
    run_window(2, 1'b1, "R3");
    run_window(-1, 1'b1, "R1");
    run_window(0, 1'b0, "R9");

    // 119-bit run: 9 tail ones, 11 full words, then a zero first bit
    push(10'h3FE, 1'b0, "R6");
    for (int k = 0; k < 11; k++) push(10'h3FF, 1'b0, "R6");
    push(10'h3FE, 1'b0, "R6");
    // 129-bit run
    for (int k = 0; k < 12; k++) push(10'h3FF, k == 11, "R6");
    push(10'h155, 1'b0, "R7");
    // polarity flip restarts the count
    for (int k = 0; k < 6; k++) push(10'h3FF, 1'b0, "R7");
    for (int k = 0; k < 12; k++) push(10'h000, k == 11, "R6");
    push(10'h3FF, 1'b0, "R7");
    for (int k = 0; k < 11; k++) push(10'h3FF, k == 10, "R6");
    push(10'h2AA, 1'b0, "R7");
    run_window(0, 1'b1, "R8");
    run_window(0, 1'b1, "R8");

    for (int k = 0; k < 2; k++) run_window(int'($urandom_range(16)) - 8, 1'b1, "R4");
    run_window(0, 1'b1, "R1");
    run_timeout();
    run_window(-1, 1'b1, "R1");
    for (int i = 0; i < 20; i++) tick(2'd1, rnd_word());
    chk(prev_tag, "freq_lock_o", freq_lock, exp_locked);
    chk(prev_tag, "lock_data_o", lock_data, exp_sel);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule